// File: doc/BRIEF.md
# Host Slave Burst Port

This block lets an external host read and write a small local memory. The host offers a start address together with a request. The port then produces every later address of the burst on its own, one word further on each beat, for as long as the host keeps its burst-continue line high. Three run-time settings shape the timing. The wait setting holds off every data beat by a fixed number of cycles. The pipeline-depth setting delays returned read data by extra register stages. The idle setting forces a quiet gap after each transaction, and requests made during that gap are ignored.

A back-off input lets the host break a deadlock. While back-off is high, the port performs no beat and drops any read data that has not yet been delivered. It raises a grant output and stops driving the data bus. When back-off is released, an interrupted transaction starts again from its original start address with a fresh wait count. It does not pick up from the beat where it stopped.

Top module: `hsb_port`

## Requirements
- R1: A request seen in the idle state loads the start address, read/write direction and later beats come from an internal counter. Each beat taken with the burst line high moves the address up by exactly one word, and the address wraps from the highest location to 0.
- R2: The burst ends on the first beat where the burst line is low. No further ready pulse follows until a new request is accepted.
- R3: With a wait setting of W, ready for the first beat rises W+1 cycles after the cycle in which the accepted request was driven. Each later beat of the burst rises W+1 cycles after the previous beat.
- R4: On a beat of a write transaction, the write data present in that cycle is stored at the current burst address.
- R5: On a beat of a read transaction, the read-data valid flag and the data-bus enable are both high for exactly one cycle, 1+P cycles after the beat, where P is the pipeline-depth setting (0 to 3). The read data carries the word stored at that beat's address.
- R6: With an idle setting of I, after the last beat the port ignores requests for I cycles. A request held high from the last beat onward therefore gets its first ready I+W+2 cycles after that beat.
- R7: While back-off is high, no beat happens. Grant is high from the cycle after back-off is first sampled until the cycle after it is sampled low. The data-bus enable is low whenever grant is high. Back-off raised with no transaction in progress still gives grant and starts nothing on release.
- R8: A transaction interrupted by back-off restarts on release from its original start address, and its first ready comes W+1 cycles after the release is driven.
- R9: Read data whose delivery cycle falls after back-off is sampled is discarded and never shows up as valid.
- R10: After reset, ready, grant, read-data valid and data-bus enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait_cyc | input | WAIT_W | Wait cycles inserted before every beat |
| cfg_idle_cyc | input | IDLE_W | Quiet cycles after the last beat of a transaction |
| cfg_pipe_depth | input | PIPE_W | Extra read-data register stages (0 to MAX_PIPE) |
| hst_req | input | 1 | Host request, sampled in the idle state |
| hst_we | input | 1 | 1 = write transaction, 0 = read, sampled with the request |
| hst_addr | input | AW | Start word address, sampled with the request |
| hst_wdata | input | DW | Write data, taken on the beat |
| hst_burst | input | 1 | High on a beat to continue with the next word |
| hst_backoff | input | 1 | Abandon the current transaction and grant the bus to the host |
| hst_rdy | output | 1 | A beat happens in this cycle |
| hst_rdata | output | DW | Read data |
| hst_rvalid | output | 1 | Read data valid |
| hst_data_oe | output | 1 | Port drives the external data bus |
| hst_grant | output | 1 | Bus granted to the host during back-off |

## Verification
The hardest case to create is a back-off that lands while a read beat's data is still inside the pipeline stages and the burst is partly done. That one event has to show the flush, the grant, the bus release and the restart from the original address. The bench starts a read burst with non-zero wait and pipeline depth, and raises back-off in the cycle right after the first beat, before its data is due. It checks that the expected word never shows up. It then releases back-off with the burst line low. The restarted beat must return the word at the start address and not its neighbour, which can only happen if the address was rewound.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  // Transaction sequencer states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for a host request
    ST_ACT  = 2'd1,  // transaction running: wait count, then a beat
    ST_GAP  = 2'd2,  // enforced quiet cycles after a transaction
    ST_HOLD = 2'd3   // backed off, bus granted to the host
  } hsb_state_e;

endpackage

// File: rtl/hsb_mem.sv
module hsb_mem #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] store [WORDS];
  logic [DW-1:0] rdata_q;

  // Single-port array with a registered read; write and read are exclusive.
  always_ff @(posedge clk) begin
    if (en && we) begin
      store[addr] <= wdata;
    end
    if (en && !we) begin
      rdata_q <= store[addr];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/hsb_seq.sv
module hsb_seq
  import hsb_pkg::*;
#(
  parameter int AW     = 6,
  parameter int WAIT_W = 4,
  parameter int IDLE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic              req,
  input  logic              we_in,
  input  logic [AW-1:0]     addr_in,
  input  logic              burst,
  input  logic              backoff,
  output logic              beat_o,
  output logic              beat_we_o,
  output logic [AW-1:0]     addr_o,
  output logic              grant_o,
  output logic              flush_o
);

  localparam int CW = (WAIT_W > IDLE_W) ? WAIT_W : IDLE_W;

  hsb_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] start_q;
  logic          we_q;
  logic          pend_q, pend_d;
  logic          addr_en;
  logic          load_en;
  logic          beat;

  // A beat needs an active transaction, an expired wait count and no back-off.
  assign beat = (state_q == ST_ACT) && (cnt_q == '0) && !backoff;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    pend_d  = pend_q;
    addr_en = 1'b0;
    load_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (backoff) begin
          state_d = ST_HOLD;
          pend_d  = 1'b0;
        end else if (req) begin
          state_d = ST_ACT;
          cnt_d   = CW'(cfg_wait);
          addr_d  = addr_in;
          addr_en = 1'b1;
          load_en = 1'b1;
        end
      end
      ST_ACT: begin
        if (backoff) begin
          state_d = ST_HOLD;
          pend_d  = 1'b1;
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - CW'(1);
        end else if (burst) begin
          cnt_d   = CW'(cfg_wait);
          addr_d  = addr_q + AW'(1);
          addr_en = 1'b1;
        end else if (cfg_idle != '0) begin
          state_d = ST_GAP;
          cnt_d   = CW'(cfg_idle) - CW'(1);
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_GAP: begin
        if (backoff) begin
          state_d = ST_HOLD;
          pend_d  = 1'b0;
        end else if (cnt_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_HOLD: begin
        if (!backoff) begin
          if (pend_q) begin
            state_d = ST_ACT;
            cnt_d   = CW'(cfg_wait);
            addr_d  = start_q;
            addr_en = 1'b1;
            pend_d  = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      start_q <= '0;
      we_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      if (addr_en) begin
        addr_q <= addr_d;
      end
      if (load_en) begin
        start_q <= addr_in;
        we_q    <= we_in;
      end
    end
  end

  assign beat_o    = beat;
  assign beat_we_o = beat && we_q;
  assign addr_o    = addr_q;
  assign grant_o   = (state_q == ST_HOLD);
  assign flush_o   = backoff || (state_q == ST_HOLD);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && burst) |=> (addr_q == AW'($past(addr_q) + AW'(1))))
    else $error("burst address did not advance by one word"); // R1

  AST_WAIT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && burst && (cfg_wait != '0)) |=> !beat)
    else $error("beat came without the programmed wait"); // R3

  AST_GAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP) |=> (state_q != ST_ACT))
    else $error("request accepted during idle gap"); // R6

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && backoff) |=> grant_o)
    else $error("grant dropped while back-off still high"); // R7

  AST_RETRY_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && !backoff && pend_q) |=> ((state_q == ST_ACT) && (addr_q == start_q)))
    else $error("retry did not restart at the start address"); // R8

endmodule

// File: rtl/hsb_rdpipe.sv
module hsb_rdpipe #(
  parameter int DW       = 32,
  parameter int MAX_PIPE = 3,
  parameter int PIPE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              flush,
  input  logic [PIPE_W-1:0] cfg_pipe,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  output logic [DW-1:0]     out_data
);

  logic          v_w [MAX_PIPE+1];
  logic [DW-1:0] d_w [MAX_PIPE+1];
  logic          v0_q;

  // Stage 0 lines up with the memory's registered read output.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0_q <= 1'b0;
    end else begin
      v0_q <= issue && !flush;
    end
  end

  assign v_w[0] = v0_q;
  assign d_w[0] = in_data;

  for (genvar gi = 1; gi <= MAX_PIPE; gi++) begin : g_stage
    logic          v_q;
    logic [DW-1:0] d_q;
    logic          d_en;

    assign d_en = v_w[gi-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= v_w[gi-1] && !flush;
        if (d_en) begin
          d_q <= d_w[gi-1];
        end
      end
    end

    assign v_w[gi] = v_q;
    assign d_w[gi] = d_q;
  end

  // Output tap picked by the depth setting; out-of-range values take the last stage.
  always_comb begin
    out_valid = v_w[MAX_PIPE];
    out_data  = d_w[MAX_PIPE];
    for (int i = 0; i < MAX_PIPE; i++) begin
      if (int'(cfg_pipe) == i) begin
        out_valid = v_w[i];
        out_data  = d_w[i];
      end
    end
  end

  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid)
    else $error("read data survived a back-off flush"); // R9

endmodule

// File: rtl/hsb_port.sv
module hsb_port #(
  parameter  int AW       = 6,
  parameter  int DW       = 32,
  parameter  int WAIT_W   = 4,
  parameter  int IDLE_W   = 4,
  parameter  int MAX_PIPE = 3,
  localparam int PIPE_W   = $clog2(MAX_PIPE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] cfg_wait_cyc,
  input  logic [IDLE_W-1:0] cfg_idle_cyc,
  input  logic [PIPE_W-1:0] cfg_pipe_depth,
  input  logic              hst_req,
  input  logic              hst_we,
  input  logic [AW-1:0]     hst_addr,
  input  logic [DW-1:0]     hst_wdata,
  input  logic              hst_burst,
  input  logic              hst_backoff,
  output logic              hst_rdy,
  output logic [DW-1:0]     hst_rdata,
  output logic              hst_rvalid,
  output logic              hst_data_oe,
  output logic              hst_grant
);

  logic          beat;
  logic          beat_we;
  logic [AW-1:0] mem_addr;
  logic          flush;
  logic [DW-1:0] mem_rdata;
  logic          rd_valid;

  hsb_seq #(
    .AW     (AW),
    .WAIT_W (WAIT_W),
    .IDLE_W (IDLE_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wait  (cfg_wait_cyc),
    .cfg_idle  (cfg_idle_cyc),
    .req       (hst_req),
    .we_in     (hst_we),
    .addr_in   (hst_addr),
    .burst     (hst_burst),
    .backoff   (hst_backoff),
    .beat_o    (beat),
    .beat_we_o (beat_we),
    .addr_o    (mem_addr),
    .grant_o   (hst_grant),
    .flush_o   (flush)
  );

  hsb_mem #(
    .AW (AW),
    .DW (DW)
  ) u_mem (
    .clk   (clk),
    .en    (beat),
    .we    (beat_we),
    .addr  (mem_addr),
    .wdata (hst_wdata),
    .rdata (mem_rdata)
  );

  hsb_rdpipe #(
    .DW       (DW),
    .MAX_PIPE (MAX_PIPE),
    .PIPE_W   (PIPE_W)
  ) u_rdpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (beat && !beat_we),
    .flush     (flush),
    .cfg_pipe  (cfg_pipe_depth),
    .in_data   (mem_rdata),
    .out_valid (rd_valid),
    .out_data  (hst_rdata)
  );

  assign hst_rdy     = beat;
  assign hst_rvalid  = rd_valid;
  assign hst_data_oe = rd_valid;

  AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hst_grant |-> (!hst_rdy && !hst_data_oe))
    else $error("port active on the bus while grant is high"); // R7

endmodule

// File: tb/hsb_port_bench.sv
module hsb_port_bench;

  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic [3:0]    cfg_wait;
  logic [3:0]    cfg_idle;
  logic [1:0]    cfg_pipe;
  logic          hst_req;
  logic          hst_we;
  logic [AW-1:0] hst_addr;
  logic [DW-1:0] hst_wdata;
  logic          hst_burst;
  logic          hst_backoff;
  logic          hst_rdy;
  logic [DW-1:0] hst_rdata;
  logic          hst_rvalid;
  logic          hst_data_oe;
  logic          hst_grant;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [DW-1:0] mdl [64];
  int            exp_cyc [256];
  logic [DW-1:0] exp_dat [256];
  int            rp = 0;
  int            wp = 0;

  hsb_port u_hsb_port (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wait_cyc   (cfg_wait),
    .cfg_idle_cyc   (cfg_idle),
    .cfg_pipe_depth (cfg_pipe),
    .hst_req        (hst_req),
    .hst_we         (hst_we),
    .hst_addr       (hst_addr),
    .hst_wdata      (hst_wdata),
    .hst_burst      (hst_burst),
    .hst_backoff    (hst_backoff),
    .hst_rdy        (hst_rdy),
    .hst_rdata      (hst_rdata),
    .hst_rvalid     (hst_rvalid),
    .hst_data_oe    (hst_data_oe),
    .hst_grant      (hst_grant)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic push_exp(input int when, input logic [DW-1:0] d);
    exp_cyc[wp] = when;
    exp_dat[wp] = d;
    wp++;
  endtask

  // Read-data monitor: every expected word must appear in exactly its cycle (R5).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rp != wp && exp_cyc[rp] == cyc) begin
        check(hst_rvalid && hst_data_oe && hst_rdata == exp_dat[rp], "R5 read data/timing",
              hst_rvalid ? hst_rdata : 32'hdead_0000, exp_dat[rp]);
        rp++;
      end else if (hst_rvalid || hst_data_oe) begin
        check(1'b0, "R5/R9 unexpected read valid", {30'd0, hst_rvalid, hst_data_oe}, 32'd0);
      end
    end
  end

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One transaction of n beats; request driven at the current negedge.
  task automatic burst_xfer(input logic [AW-1:0] a, input bit we, input int n,
                            input logic [DW-1:0] base, input int first_lat, input bit settle);
    int lat;
    hst_addr = a;
    hst_we   = we;
    hst_req  = 1'b1;
    for (int b = 0; b < n; b++) begin
      int expl;
      logic [AW-1:0] ba;
      lat = 0;
      do begin
        @(negedge clk);
        lat++;
      end while (!hst_rdy && lat < 60);
      expl = (b == 0) ? first_lat : int'(cfg_wait) + 1;
      check(lat == expl, (b == 0) ? "R3/R6 first ready latency" : "R3 beat spacing", lat, expl);
      hst_req = 1'b0;
      ba = a + AW'(b);
      if (we) begin
        hst_wdata = base + b;
        mdl[ba]   = base + b;
      end else begin
        push_exp(cyc + 1 + int'(cfg_pipe), mdl[ba]);
      end
      hst_burst = (b != n - 1);
    end
    if (settle) begin
      for (int k = 0; k < int'(cfg_wait) + 3; k++) begin
        @(negedge clk);
        hst_burst = 1'b0;
        check(!hst_rdy, "R2 no beat after burst end", hst_rdy, 0);
      end
    end
  endtask

  task automatic test_reset();
    check(!hst_rdy && !hst_grant && !hst_rvalid && !hst_data_oe, "R10 reset outputs",
          {28'd0, hst_rdy, hst_grant, hst_rvalid, hst_data_oe}, 0);
  endtask

  task automatic test_basic();
    cfg_wait = 0; cfg_idle = 0; cfg_pipe = 0;
    burst_xfer(6'd4, 1'b1, 4, 32'hA000_0010, 1, 1'b1);     // R4 R1
    burst_xfer(6'd4, 1'b0, 4, 0, 1, 1'b1);                  // R5 R1
    idle_cycles(6);
  endtask

  task automatic test_wait_pipe();
    cfg_wait = 2; cfg_pipe = 2;
    burst_xfer(6'd5, 1'b0, 3, 0, 3, 1'b1);                  // R3 R5
    cfg_wait = 0; cfg_pipe = 1;
    burst_xfer(6'd4, 1'b0, 2, 0, 1, 1'b1);
    idle_cycles(6);
  endtask

  task automatic test_wrap();
    cfg_wait = 1; cfg_pipe = 3;
    burst_xfer(6'd62, 1'b1, 3, 32'hB000_0000, 2, 1'b1);     // R1 wrap to 0
    burst_xfer(6'd63, 1'b0, 2, 0, 2, 1'b1);
    idle_cycles(8);
  endtask

  task automatic test_idle_gap();
    cfg_wait = 1; cfg_idle = 3; cfg_pipe = 0;
    burst_xfer(6'd10, 1'b1, 2, 32'hC000_0000, 2, 1'b0);
    // request held from the last beat: first ready after I+W+2 cycles (R6)
    burst_xfer(6'd10, 1'b0, 2, 0, 3 + 1 + 2, 1'b1);
    cfg_idle = 0;
    idle_cycles(6);
  endtask

  task automatic test_backoff_retry();
    int lat;
    cfg_wait = 2; cfg_pipe = 1; cfg_idle = 0;
    burst_xfer(6'd20, 1'b1, 3, 32'hD000_0000, 3, 1'b1);
    idle_cycles(4);
    hst_addr = 6'd20; hst_we = 1'b0; hst_req = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!hst_rdy && lat < 60);
    check(lat == 3, "R3 first beat before back-off", lat, 3);
    hst_req = 1'b0;
    hst_burst = 1'b1;
    push_exp(cyc + 2, mdl[20]);
    @(negedge clk);
    hst_backoff = 1'b1;
    // the beat's data is due later: it must be discarded (R9)
    while (wp != rp && exp_cyc[wp-1] > cyc) wp--;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(hst_grant && !hst_data_oe && !hst_rdy && !hst_rvalid, "R7/R9 back-off hold",
            {28'd0, hst_grant, hst_data_oe, hst_rdy, hst_rvalid}, 32'h8);
    end
    hst_backoff = 1'b0;
    hst_burst = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) check(!hst_grant, "R7 grant released", hst_grant, 0);
    end while (!hst_rdy && lat < 60);
    check(lat == 3, "R8 retry wait count", lat, 3);
    push_exp(cyc + 2, mdl[20]);                              // R8 original address
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!hst_rdy, "R2 retry single beat", hst_rdy, 0);
    end
    idle_cycles(4);
  endtask

  task automatic test_backoff_idle();
    hst_backoff = 1'b1;
    @(negedge clk);
    check(hst_grant, "R7 grant from idle", hst_grant, 1);
    @(negedge clk);
    hst_backoff = 1'b0;
    @(negedge clk);
    check(!hst_grant, "R7 grant drops after release", hst_grant, 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!hst_rdy, "R7 nothing starts after idle back-off", hst_rdy, 0);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_wait = 0; cfg_idle = 0; cfg_pipe = 0;
    hst_req = 0; hst_we = 0; hst_addr = 0; hst_wdata = 0;
    hst_burst = 0; hst_backoff = 0;
    idle_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_basic();
    test_wait_pipe();
    test_wrap();
    test_idle_gap();
    test_backoff_retry();
    test_backoff_idle();
    idle_cycles(8);
    check(rp == wp, "R5 all expected read data delivered", wp - rp, 0);
    finish_run();
  end

  initial begin
    #2000000;
    if (!done) begin
      check(1'b0, "watchdog expired", cyc, 0);
      finish_run();
    end
  end

endmodule